// File: doc/BRIEF.md
# Bit-serial audio link frame engine (codec side)

This block is the serial port a codec uses on a five-wire audio link. It runs on the bit clock that arrives at `sclk`. It samples the controller's serial stream and the frame marker on falling edges, and it launches its own serial stream on rising edges. Each frame is 256 bits long. It starts with a 16-bit tag slot, and twelve 20-bit data slots follow. Every slot is sent and received most significant bit first.

On the receive side, each slot is deserialized as it arrives. Each completed slot is handed to the core as a parallel word, marked with its slot number and a one-cycle strobe. A second strobe marks the end of the frame. The transmit side builds the outgoing tag from a ready flag and twelve per-slot valid flags. It then sends each slot's payload, or zeros when that slot's valid flag is clear.

The frame counter locks on the first low-to-high transition of `fsync` that is sampled on a falling edge. A later transition at any position other than the frame's final bit restarts the frame and raises a sticky error flag.

Top module: `aclink_frame_port`

## Requirements
- R1: While `rst` is high, and on the falling edge after it is released, `rx_word_vld`, `frame_done`, `frame_err`, `rx_tag` and `ser_tx` are all 0.
- R2: Until the first low-to-high `fsync` transition has been sampled, `ser_tx` stays 0, no slot word is reported and `ser_rx` has no effect.
- R3: The bit sampled on the falling edge that first sees `fsync` high belongs to the previous frame. It is F255, or it is discarded before lock. The next falling edge samples F0. Slot 0 spans F0..F15. Data slot s (1..12) spans F(16+20(s-1))..F(35+20(s-1)). Each slot arrives MSB first.
- R4: On the falling edge that samples a slot's last bit, `rx_word` takes the slot value and `rx_slot` takes the slot number (0..12). `rx_word_vld` is high for exactly that one cycle. The tag word appears zero-extended in `rx_word[15:0]`.
- R5: `rx_tag` is updated with the 16-bit tag at the end of each received slot 0. It holds its value otherwise.
- R6: `frame_done` pulses for one cycle, together with the slot 12 word, and never at any other time.
- R7: F0 of the outgoing frame is launched on the rising edge that follows the `fsync` detection edge. One bit follows on each rising edge after that, in the same slot layout as R3 and MSB first.
- R8: The outgoing tag carries `tx_ready` in bit 15 and `tx_valid[s-1]` in bit 15-s for s = 1..12. Bits 2..0 are 0.
- R9: Outgoing data slot s carries `tx_slot_data[20(s-1)+19 : 20(s-1)]` when `tx_valid[s-1]` is 1, and twenty zeros otherwise. The value is sampled at that slot's first bit.
- R10: A low-to-high `fsync` at any position other than F255 restarts the frame at F0 and discards the partly received slot. It also sets `frame_err`, which stays set until reset. The first lock and aligned markers never set it.
- R11: Only the low-to-high transition of `fsync` marks a frame. Holding it high through the tag slot does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame marker from the controller |
| ser_rx | input | 1 | Serial data from the controller |
| ser_tx | output | 1 | Serial data to the controller |
| tx_ready | input | 1 | Ready flag placed in the outgoing tag |
| tx_valid | input | 12 | Per-slot valid flags, bit 0 = slot 1 |
| tx_slot_data | input | 240 | Outgoing payloads, slot 1 in the low 20 bits |
| rx_word | output | 20 | Last received slot value |
| rx_slot | output | 4 | Slot number of `rx_word` |
| rx_word_vld | output | 1 | One-cycle strobe for a new slot word |
| rx_tag | output | 16 | Last received tag |
| frame_done | output | 1 | One-cycle strobe at the end of a frame |
| frame_err | output | 1 | Sticky misaligned-marker flag |

## Verification
The stream is first run idle, with `ser_rx` toggling and no marker, which shows that nothing is reported or driven before lock. Two aligned frames follow. One has every slot valid and distinct payloads. The other has a sparse valid pattern and an inverted payload, so a swapped slot order, a wrong tag bit position or a leak from an invalid slot each produce a different word. A marker placed at bit 100, inside slot 5, then shows that completed slots survive, the partial slot is dropped and the error flag is set. A final all-invalid frame confirms that the error flag stays set and that the restarted frame lines up.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
    localparam int TAG_BITS   = 16;
    localparam int SLOT_BITS  = 20;
    localparam int DATA_SLOTS = 12;
    localparam int SLOT_IDX_W = $clog2(DATA_SLOTS + 1);
    localparam int BIT_IDX_W  = $clog2(SLOT_BITS);
    localparam int TAG_PAD    = SLOT_BITS - TAG_BITS;

    typedef logic [SLOT_IDX_W-1:0] slot_idx_t;
    typedef logic [BIT_IDX_W-1:0]  bit_idx_t;
    typedef logic [SLOT_BITS-1:0]  slot_word_t;
    typedef logic [TAG_BITS-1:0]   tag_word_t;

    typedef struct packed {
        slot_idx_t slot;
        bit_idx_t  bit_n;
    } frame_pos_t;

    typedef struct packed {
        logic       vld;
        logic       done;
        slot_idx_t  slot;
        slot_word_t word;
    } rx_beat_t;

    // true on the final bit of the current slot (tag slot is shorter)
    function automatic logic is_slot_end(frame_pos_t p);
        if (p.slot == '0)
            return p.bit_n == bit_idx_t'(TAG_BITS - 1);
        return p.bit_n == bit_idx_t'(SLOT_BITS - 1);
    endfunction

    function automatic logic is_frame_end(frame_pos_t p);
        return (p.slot == slot_idx_t'(DATA_SLOTS)) && is_slot_end(p);
    endfunction

    function automatic frame_pos_t next_pos(frame_pos_t p);
        frame_pos_t n;
        if (!is_slot_end(p)) begin
            n.slot  = p.slot;
            n.bit_n = p.bit_n + 1'b1;
        end else if (p.slot == slot_idx_t'(DATA_SLOTS)) begin
            n = '0;
        end else begin
            n.slot  = p.slot + 1'b1;
            n.bit_n = '0;
        end
        return n;
    endfunction
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer
    import aclink_pkg::*;
(
    input  logic       sclk,
    input  logic       rst,
    input  logic       fsync,
    output frame_pos_t pos,
    output logic       locked,
    output logic       sync_rise,
    output logic       frame_err
);
    logic sync_q;

    // only a low-to-high sample marks a frame
    assign sync_rise = fsync & ~sync_q;

    always_ff @(negedge sclk) begin
        if (rst) begin
            sync_q    <= 1'b0;
            locked    <= 1'b0;
            pos       <= '0;
            frame_err <= 1'b0;
        end else begin
            sync_q <= fsync;
            if (sync_rise) begin
                locked <= 1'b1;
                pos    <= '0;
                if (locked && !is_frame_end(pos))
                    frame_err <= 1'b1;
            end else if (locked) begin
                pos <= next_pos(pos);
            end
        end
    end
endmodule

// File: rtl/aclink_rx_deser.sv
module aclink_rx_deser
    import aclink_pkg::*;
(
    input  logic       sclk,
    input  logic       rst,
    input  logic       ser_rx,
    input  logic       locked,
    input  logic       sync_rise,
    input  frame_pos_t pos,
    output rx_beat_t   beat,
    output tag_word_t  tag
);
    localparam int SH_W = SLOT_BITS - 1;

    logic [SH_W-1:0] sh;
    slot_word_t      word_now;
    logic            capture;

    assign word_now = {sh, ser_rx};
    // a slot ending on a misaligned marker edge is a partial slot: drop it
    assign capture  = locked && is_slot_end(pos) && (is_frame_end(pos) || !sync_rise);

    always_ff @(negedge sclk) begin
        if (rst) begin
            sh   <= '0;
            beat <= '0;
            tag  <= '0;
        end else begin
            if (pos.bit_n == '0)
                sh <= SH_W'(ser_rx);
            else
                sh <= {sh[SH_W-2:0], ser_rx};
            beat.vld  <= capture;
            beat.done <= capture && is_frame_end(pos);
            if (capture) begin
                beat.slot <= pos.slot;
                beat.word <= word_now;
                if (pos.slot == '0)
                    tag <= word_now[TAG_BITS-1:0];
            end
        end
    end
endmodule

// File: rtl/aclink_tx_ser.sv
module aclink_tx_ser
    import aclink_pkg::*;
(
    input  logic                            sclk,
    input  logic                            rst,
    input  logic                            locked,
    input  frame_pos_t                      pos,
    input  logic                            tx_ready,
    input  logic [DATA_SLOTS-1:0]           tx_valid,
    input  logic [DATA_SLOTS*SLOT_BITS-1:0] tx_slot_data,
    output logic                            ser_tx
);
    tag_word_t  tag;
    slot_word_t words [DATA_SLOTS+1];
    slot_word_t load_word;
    slot_word_t sh;

    assign tag[TAG_BITS-1] = tx_ready;
    assign tag[TAG_BITS-2-DATA_SLOTS:0] = '0;

    genvar g;
    for (g = 0; g < DATA_SLOTS; g++) begin : g_tag
        assign tag[TAG_BITS-2-g] = tx_valid[g];
    end

    // tag is left-aligned in a slot-wide container so one shifter serves all
    assign words[0] = {tag, {TAG_PAD{1'b0}}};
    for (g = 0; g < DATA_SLOTS; g++) begin : g_word
        assign words[g+1] = tx_valid[g] ? tx_slot_data[g*SLOT_BITS +: SLOT_BITS] : '0;
    end

    assign load_word = words[pos.slot];

    always_ff @(posedge sclk) begin
        if (rst || !locked) begin
            sh     <= '0;
            ser_tx <= 1'b0;
        end else if (pos.bit_n == '0) begin
            ser_tx <= load_word[SLOT_BITS-1];
            sh     <= load_word << 1;
        end else begin
            ser_tx <= sh[SLOT_BITS-1];
            sh     <= sh << 1;
        end
    end
endmodule

// File: rtl/aclink_frame_port.sv
module aclink_frame_port
    import aclink_pkg::*;
(
    input  logic                            sclk,
    input  logic                            rst,
    input  logic                            fsync,
    input  logic                            ser_rx,
    output logic                            ser_tx,
    input  logic                            tx_ready,
    input  logic [DATA_SLOTS-1:0]           tx_valid,
    input  logic [DATA_SLOTS*SLOT_BITS-1:0] tx_slot_data,
    output logic [SLOT_BITS-1:0]            rx_word,
    output logic [SLOT_IDX_W-1:0]           rx_slot,
    output logic                            rx_word_vld,
    output logic [TAG_BITS-1:0]             rx_tag,
    output logic                            frame_done,
    output logic                            frame_err
);
    frame_pos_t pos;
    logic       locked;
    logic       sync_rise;
    rx_beat_t   beat;

    aclink_frame_timer u_timer (
        .sclk      (sclk),
        .rst       (rst),
        .fsync     (fsync),
        .pos       (pos),
        .locked    (locked),
        .sync_rise (sync_rise),
        .frame_err (frame_err)
    );

    aclink_rx_deser u_rx (
        .sclk      (sclk),
        .rst       (rst),
        .ser_rx    (ser_rx),
        .locked    (locked),
        .sync_rise (sync_rise),
        .pos       (pos),
        .beat      (beat),
        .tag       (rx_tag)
    );

    aclink_tx_ser u_tx (
        .sclk         (sclk),
        .rst          (rst),
        .locked       (locked),
        .pos          (pos),
        .tx_ready     (tx_ready),
        .tx_valid     (tx_valid),
        .tx_slot_data (tx_slot_data),
        .ser_tx       (ser_tx)
    );

    assign rx_word     = beat.word;
    assign rx_slot     = beat.slot;
    assign rx_word_vld = beat.vld;
    assign frame_done  = beat.done;
endmodule

// File: rtl/aclink_frame_port_chk.sv
module aclink_frame_port_chk
    import aclink_pkg::*;
(
    input logic                  sclk,
    input logic                  rst,
    input logic                  fsync,
    input logic                  ser_tx,
    input logic                  locked,
    input logic                  rx_word_vld,
    input logic                  frame_done,
    input logic                  frame_err,
    input logic [SLOT_IDX_W-1:0] rx_slot,
    input logic [SLOT_BITS-1:0]  rx_word,
    input logic [TAG_BITS-1:0]   rx_tag
);
    AST_TX_QUIET_UNLOCKED: assert property (@(posedge sclk) disable iff (rst)
        !locked |=> !ser_tx); // R2

    AST_NO_WORD_UNLOCKED: assert property (@(negedge sclk) disable iff (rst)
        !locked |=> !rx_word_vld); // R2

    AST_WORD_PULSE_SINGLE: assert property (@(negedge sclk) disable iff (rst)
        rx_word_vld |=> !rx_word_vld); // R4

    AST_TAG_FOLLOWS_SLOT0: assert property (@(negedge sclk) disable iff (rst)
        (rx_word_vld && rx_slot == '0) |-> (rx_tag == rx_word[TAG_BITS-1:0])); // R5

    AST_DONE_WITH_LAST: assert property (@(negedge sclk) disable iff (rst)
        frame_done |-> (rx_word_vld && rx_slot == SLOT_IDX_W'(DATA_SLOTS))); // R6

    AST_ERR_STICKY: assert property (@(negedge sclk) disable iff (rst)
        frame_err |=> frame_err); // R10

    AST_ERR_ON_MARKER: assert property (@(negedge sclk) disable iff (rst)
        $rose(frame_err) |-> ($past(fsync) && !$past(fsync, 2))); // R10
endmodule

bind aclink_frame_port aclink_frame_port_chk u_chk (
    .sclk        (sclk),
    .rst         (rst),
    .fsync       (fsync),
    .ser_tx      (ser_tx),
    .locked      (locked),
    .rx_word_vld (rx_word_vld),
    .frame_done  (frame_done),
    .frame_err   (frame_err),
    .rx_slot     (rx_slot),
    .rx_word     (rx_word),
    .rx_tag      (rx_tag)
);

// File: tb/aclink_frame_port_tb.sv
module aclink_frame_port_tb;
    localparam int CLK_PERIOD = 80;
    localparam int NSLOT = 12;
    localparam int SW    = 20;
    localparam int TW    = 16;
    localparam int FB    = 256;

    logic                sclk = 1'b0;
    logic                rst = 1'b1;
    logic                fsync = 1'b0;
    logic                ser_rx = 1'b0;
    logic                ser_tx;
    logic                tx_ready = 1'b0;
    logic [NSLOT-1:0]    tx_valid = '0;
    logic [NSLOT*SW-1:0] tx_slot_data = '0;
    logic [SW-1:0]       rx_word;
    logic [3:0]          rx_slot;
    logic                rx_word_vld;
    logic [TW-1:0]       rx_tag;
    logic                frame_done;
    logic                frame_err;

    int total = 0;
    int bad = 0;

    typedef struct packed {
        logic [3:0]    slot;
        logic [SW-1:0] word;
        logic          done;
    } exp_t;
    exp_t expq[$];

    always #(CLK_PERIOD/2) sclk = ~sclk;

    aclink_frame_port u_dut (
        .sclk(sclk), .rst(rst), .fsync(fsync), .ser_rx(ser_rx), .ser_tx(ser_tx),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_slot_data(tx_slot_data),
        .rx_word(rx_word), .rx_slot(rx_slot), .rx_word_vld(rx_word_vld),
        .rx_tag(rx_tag), .frame_done(frame_done), .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int slot_end(int s);
        return (s == 0) ? TW - 1 : TW + SW * s - 1;
    endfunction

    // expected outgoing slot, right-aligned (R8, R9)
    function automatic logic [SW-1:0] tx_expect(int s, logic rdy, logic [NSLOT-1:0] v,
                                                logic [NSLOT*SW-1:0] d);
        logic [TW-1:0] t;
        if (s == 0) begin
            t = '0;
            t[15] = rdy;
            for (int g = 0; g < NSLOT; g++) t[14-g] = v[g];
            return {4'h0, t};
        end
        return v[s-1] ? d[(s-1)*SW +: SW] : '0;
    endfunction

    // one frame from the controller side; the marker rises with bit 'last'
    task automatic run_frame(input logic [13*SW-1:0] ctl, input int last, input logic rdy,
                             input logic [NSLOT-1:0] v, input logic [NSLOT*SW-1:0] d);
        logic [SW-1:0] got;
        tx_ready = rdy;
        tx_valid = v;
        tx_slot_data = d;
        for (int s = 0; s <= NSLOT; s++) begin
            if (slot_end(s) < last || last == FB - 1)
                expq.push_back({4'(s), ctl[s*SW +: SW], s == NSLOT});
        end
        got = '0;
        for (int n = 0; n <= last; n++) begin
            int s;
            int off;
            int len;
            logic [SW-1:0] e;
            logic [SW-1:0] mask;
            if (n < TW) begin s = 0; off = n; end
            else begin s = 1 + (n - TW) / SW; off = (n - TW) % SW; end
            len = (s == 0) ? TW : SW;
            @(posedge sclk);
            #(CLK_PERIOD/4);
            got = {got[SW-2:0], ser_tx};
            fsync = (n <= 14) || (n == last);   // held high through the tag: R11
            ser_rx = ctl[s*SW + len - 1 - off];
            if (off == len - 1) begin
                e = tx_expect(s, rdy, v, d);
                mask = (s == 0) ? 20'h0FFFF : 20'hFFFFF;
                check((got & mask) == e, (s == 0) ? "R8/R7" : "R9/R7",
                      $sformatf("tx slot %0d", s), got & mask, e);
            end
        end
    endtask

    // scoreboard monitor for received words (R3 R4 R5 R6)
    initial begin
        forever begin
            @(negedge sclk);
            #(CLK_PERIOD/4);
            if (!rst) begin
                if (rx_word_vld) begin
                    if (expq.size() == 0) begin
                        check(1'b0, "R2/R4", "unexpected slot word", rx_slot, 0);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        check(rx_slot == e.slot, "R4", "rx slot index", rx_slot, e.slot);
                        check(rx_word == e.word, "R3", $sformatf("rx word slot %0d", e.slot),
                              rx_word, e.word);
                        check(frame_done == e.done, "R6", "frame done with word", frame_done, e.done);
                        if (e.slot == 0)
                            check(rx_tag == e.word[TW-1:0], "R5", "rx tag", rx_tag, e.word[TW-1:0]);
                    end
                end else if (frame_done) begin
                    check(1'b0, "R6", "frame done without word", 1, 0);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog", "run did not end", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [13*SW-1:0] make_ctl(int seed);
        logic [13*SW-1:0] c;
        c = '0;
        c[TW-1:0] = 16'hC3A1 ^ 16'(seed * 16'h1357);
        for (int s = 1; s <= NSLOT; s++)
            c[s*SW +: SW] = 20'(s * 20'h0B3C5) ^ 20'(seed * 20'h5A5A5);
        return c;
    endfunction

    initial begin
        logic [NSLOT*SW-1:0] d1;
        logic [13*SW-1:0]    c;
        bit idle_ok;
        for (int s = 0; s < NSLOT; s++) d1[s*SW +: SW] = 20'((s + 1) * 20'h11111);

        repeat (4) @(posedge sclk);
        #(CLK_PERIOD/4);
        check(rx_word_vld == 0, "R1", "vld in reset", rx_word_vld, 0);
        check(frame_done == 0, "R1", "done in reset", frame_done, 0);
        check(frame_err == 0, "R1", "err in reset", frame_err, 0);
        check(ser_tx == 0, "R1", "ser_tx in reset", ser_tx, 0);
        check(rx_tag == 0, "R1", "tag in reset", rx_tag, 0);
        rst = 1'b0;

        // idle, no marker, ser_rx toggling (R2)
        idle_ok = 1'b1;
        tx_ready = 1'b1;
        tx_valid = '1;
        tx_slot_data = d1;
        for (int n = 0; n < 12; n++) begin
            @(posedge sclk);
            #(CLK_PERIOD/4);
            if (ser_tx !== 1'b0) idle_ok = 1'b0;
            ser_rx = n[0];
        end
        check(idle_ok, "R2", "ser_tx idle before lock", ser_tx, 0);

        // first marker; its data bit must be discarded (R3)
        @(posedge sclk);
        #(CLK_PERIOD/4);
        fsync = 1'b1;
        ser_rx = 1'b1;

        run_frame(make_ctl(1), FB - 1, 1'b1, 12'hFFF, d1);
        check(frame_err == 0, "R10", "no error at first lock", frame_err, 0);

        run_frame(make_ctl(2), FB - 1, 1'b0, 12'b1010_0101_1100, ~d1);
        check(frame_err == 0, "R10", "no error at aligned marker", frame_err, 0);

        // marker inside slot 5: slots 0..4 kept, slot 5 dropped (R10)
        run_frame(make_ctl(3), 100, 1'b1, 12'h000, d1);
        @(negedge sclk);
        #(CLK_PERIOD/4);
        check(frame_err == 1, "R10", "error after early marker", frame_err, 1);

        c = make_ctl(4);
        run_frame(c, FB - 1, 1'b1, 12'h000, '1);
        check(frame_err == 1, "R10", "error stays set", frame_err, 1);

        repeat (4) @(posedge sclk);
        fsync = 1'b0;
        check(expq.size() == 0, "R6", "all expected words seen", expq.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule